// File: doc/BRIEF.md
# Fully Associative Translation Buffer

This block holds a small set of recent virtual-to-physical page translations. Every lookup compares its virtual page number against all entries at once. The matching entry's physical frame number is selected through a one-hot OR multiplexer and joined to the untranslated page offset. The default geometry is 32 entries, a 30-bit page tag, a 13-bit offset (8 KB pages) and a 21-bit frame, which gives a 34-bit physical address. Each entry also has its own 2-bit read and 2-bit write permission fields. These are checked against the access type and the privilege mode of the request.

After a miss, the surrounding walker writes a translation through the fill port. The entry it replaces is chosen pseudo-randomly by a free-running LFSR, and the most recently filled slot is never picked. A flush input clears the whole table on a context switch. An invalidate input drops every entry whose tag matches a page table entry that software has just modified.

Top module: `tlb_fa`

## Requirements
- R1: A lookup whose page number matches exactly one valid entry, and whose access passes that entry's permission check, reports a hit. The physical address is {entry frame, request offset}.
- R2: A lookup that matches no valid entry reports a miss, with a physical address of zero.
- R3: A lookup result appears on the clock edge after the request is sampled, and exactly one of hit, miss or fault is set. In a cycle after which no request was sampled, all three flags and the address are zero.
- R4: A read checks the read field and a write checks the write field. Bit 0 of a field grants supervisor access and bit 1 grants user access. A failed check reports a fault, never a miss, with a physical address of zero.
- R5: A lookup that matches two or more valid entries reports a miss.
- R6: A flush empties the whole table at the next edge, so later lookups miss. A fill in the same cycle as a flush is discarded.
- R7: An invalidate clears every valid entry whose tag equals the given tag, and leaves entries with other tags able to hit.
- R8: A fill never replaces the slot written by the previous fill. Two back-to-back fills with distinct tags both stay resident. Filling the same tag twice in a row creates two matching copies.
- R9: A lookup sees the table as it was before the edge. A lookup in the same cycle as the fill of its tag misses, and the next lookup of that tag hits.
- R10: After reset every entry is invalid and all result outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_req | input | 1 | Lookup request |
| lk_vaddr | input | 43 | Virtual address: page tag in the high 30 bits, offset in the low 13 |
| lk_write | input | 1 | Access type: 1 write, 0 read |
| lk_super | input | 1 | Privilege: 1 supervisor, 0 user |
| fill_en | input | 1 | Write a new entry |
| fill_tag | input | 30 | Tag of the new entry |
| fill_ppn | input | 21 | Frame number of the new entry |
| fill_rd | input | 2 | Read permission of the new entry |
| fill_wr | input | 2 | Write permission of the new entry |
| flush_all | input | 1 | Invalidate every entry |
| inv_en | input | 1 | Invalidate entries matching inv_tag |
| inv_tag | input | 30 | Tag to invalidate |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_miss | output | 1 | No single valid match |
| rsp_fault | output | 1 | Permission check failed |
| rsp_paddr | output | 34 | Physical address on a hit, zero otherwise |

## Verification
Lookup flags and the physical address are registered, so each result is due exactly one rising edge after the request is sampled. Fill, flush and invalidate change the table on the edge that samples them, so their effect appears in the result of a lookup issued in the following cycle. The bench drives every input on the falling edge and reads the outputs on the next falling edge, halfway after the edge that produces them. Random victim choice makes residency of older fills uncertain, so the bench's own model accepts either a correct hit or a miss for those tags, and demands an exact result for absent tags and for the tag filled most recently.

// File: rtl/tlb_fa.sv
module tlb_fa #(
  parameter int ENTRIES = 32,
  parameter int TAG_W   = 30,
  parameter int OFF_W   = 13,
  parameter int PPN_W   = 21
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     lk_req,
  input  logic [TAG_W+OFF_W-1:0]   lk_vaddr,
  input  logic                     lk_write,
  input  logic                     lk_super,
  input  logic                     fill_en,
  input  logic [TAG_W-1:0]         fill_tag,
  input  logic [PPN_W-1:0]         fill_ppn,
  input  logic [1:0]               fill_rd,
  input  logic [1:0]               fill_wr,
  input  logic                     flush_all,
  input  logic                     inv_en,
  input  logic [TAG_W-1:0]         inv_tag,
  output logic                     rsp_hit,
  output logic                     rsp_miss,
  output logic                     rsp_fault,
  output logic [PPN_W+OFF_W-1:0]   rsp_paddr
);

  localparam int IDX_W = $clog2(ENTRIES);
  localparam int VA_W  = TAG_W + OFF_W;
  localparam int PA_W  = PPN_W + OFF_W;

  function automatic logic [IDX_W-1:0] tap_mask();
    case (IDX_W)
      2:       return IDX_W'(8'b0000_0011);
      3:       return IDX_W'(8'b0000_0110);
      4:       return IDX_W'(8'b0000_1100);
      5:       return IDX_W'(8'b0001_0100);
      6:       return IDX_W'(8'b0011_0000);
      7:       return IDX_W'(8'b0110_0000);
      default: return IDX_W'(8'b1011_1000);
    endcase
  endfunction

  localparam logic [IDX_W-1:0] TAPS = tap_mask();

  logic [TAG_W-1:0] tag_q [ENTRIES];
  logic [PPN_W-1:0] ppn_q [ENTRIES];
  logic [1:0]       rd_q  [ENTRIES];
  logic [1:0]       wr_q  [ENTRIES];
  logic [ENTRIES-1:0] valid_q;

  logic [IDX_W-1:0] lfsr_q, last_q, victim;
  logic [ENTRIES-1:0] match;
  logic [PPN_W-1:0] sel_ppn;
  logic [1:0] sel_rd, sel_wr, field;
  logic single, allowed, do_fill;

  wire [TAG_W-1:0] vpn = lk_vaddr[VA_W-1:OFF_W];
  wire [OFF_W-1:0] off = lk_vaddr[OFF_W-1:0];

  genvar gi;
  generate
    for (gi = 0; gi < ENTRIES; gi++) begin : g_cmp
      assign match[gi] = valid_q[gi] && (tag_q[gi] == vpn);
    end
  endgenerate

  always_comb begin
    sel_ppn = '0;
    sel_rd  = '0;
    sel_wr  = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match[i]) begin
        sel_ppn = sel_ppn | ppn_q[i];
        sel_rd  = sel_rd  | rd_q[i];
        sel_wr  = sel_wr  | wr_q[i];
      end
    end
  end

  assign single  = (|match) && ((match & (match - 1'b1)) == '0);
  assign field   = lk_write ? sel_wr : sel_rd;
  assign allowed = lk_super ? field[0] : field[1];
  assign victim  = (lfsr_q == last_q) ? lfsr_q + 1'b1 : lfsr_q;
  assign do_fill = fill_en && !flush_all;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_hit   <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_paddr <= '0;
    end else begin
      rsp_hit   <= lk_req && single && allowed;
      rsp_fault <= lk_req && single && !allowed;
      rsp_miss  <= lk_req && !single;
      rsp_paddr <= (lk_req && single && allowed) ? {sel_ppn, off} : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lfsr_q <= IDX_W'(1);
      last_q <= '0;
    end else begin
      lfsr_q <= (lfsr_q >> 1) ^ (lfsr_q[0] ? TAPS : '0);
      if (do_fill) last_q <= victim;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else if (flush_all) begin
      valid_q <= '0;
    end else begin
      for (int i = 0; i < ENTRIES; i++)
        if (inv_en && tag_q[i] == inv_tag) valid_q[i] <= 1'b0;
      if (fill_en) valid_q[victim] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (do_fill) begin
      tag_q[victim] <= fill_tag;
      ppn_q[victim] <= fill_ppn;
      rd_q[victim]  <= fill_rd;
      wr_q[victim]  <= fill_wr;
    end
  end

  a_r3_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rsp_hit, rsp_miss, rsp_fault}));

  a_r3_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(lk_req) |-> !(rsp_hit || rsp_miss || rsp_fault) && rsp_paddr == '0);

  a_r3_req_answers: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req |=> (rsp_hit || rsp_miss || rsp_fault));

  a_r4_no_addr_unless_hit: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_hit |-> rsp_paddr == PA_W'(0));

  a_r6_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush_all |=> valid_q == '0);

  a_r8_new_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && !flush_all) |=> last_q != $past(last_q));

endmodule

// File: tb/tlb_fa_test.sv
`timescale 1ns/1ps
module tlb_fa_test;
  localparam int TAG_W = 30, OFF_W = 13, PPN_W = 21;
  localparam int NPOOL = 32;

  logic clk = 0, rst_n = 0;
  logic lk_req = 0, lk_write = 0, lk_super = 0;
  logic [TAG_W+OFF_W-1:0] lk_vaddr = '0;
  logic fill_en = 0, flush_all = 0, inv_en = 0;
  logic [TAG_W-1:0] fill_tag = '0, inv_tag = '0;
  logic [PPN_W-1:0] fill_ppn = '0;
  logic [1:0] fill_rd = 0, fill_wr = 0;
  logic rsp_hit, rsp_miss, rsp_fault;
  logic [PPN_W+OFF_W-1:0] rsp_paddr;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tlb_fa uut (.clk, .rst_n, .lk_req, .lk_vaddr, .lk_write, .lk_super,
              .fill_en, .fill_tag, .fill_ppn, .fill_rd, .fill_wr,
              .flush_all, .inv_en, .inv_tag,
              .rsp_hit, .rsp_miss, .rsp_fault, .rsp_paddr);

  function automatic logic [PPN_W-1:0] ppn_of(logic [TAG_W-1:0] t);
    return t[PPN_W-1:0] ^ 21'h15A5A;
  endfunction

  function automatic bit perm_ok(logic [1:0] f, bit sup);
    return sup ? f[0] : f[1];
  endfunction

  function automatic logic [36:0] exp_hit(logic [PPN_W-1:0] p, logic [OFF_W-1:0] o);
    return {3'b100, p, o};
  endfunction
  localparam logic [36:0] EXP_MISS  = {3'b010, 34'd0};
  localparam logic [36:0] EXP_FAULT = {3'b001, 34'd0};
  localparam logic [36:0] EXP_IDLE  = 37'd0;

  function automatic logic [36:0] result();
    return {rsp_hit, rsp_miss, rsp_fault, rsp_paddr};
  endfunction

  task automatic check(input string rq, input logic [36:0] act, input logic [36:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic fill(input logic [TAG_W-1:0] t, input logic [1:0] r, input logic [1:0] w);
    fill_en = 1; fill_tag = t; fill_ppn = ppn_of(t); fill_rd = r; fill_wr = w;
    @(negedge clk);
    fill_en = 0;
  endtask

  task automatic lookup(input logic [TAG_W-1:0] t, input logic [OFF_W-1:0] o,
                        input bit wr, input bit sup, output logic [36:0] res);
    lk_req = 1; lk_vaddr = {t, o}; lk_write = wr; lk_super = sup;
    @(negedge clk);
    lk_req = 0;
    res = result();
  endtask

  task automatic pulse_flush();
    flush_all = 1; @(negedge clk); flush_all = 0;
  endtask

  task automatic pulse_inv(input logic [TAG_W-1:0] t);
    inv_en = 1; inv_tag = t; @(negedge clk); inv_en = 0;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  logic [TAG_W-1:0] pool_tag [NPOOL];
  logic [1:0] pool_rd [NPOOL], pool_wr [NPOOL];
  int pool_st [NPOOL];

  initial begin
    logic [36:0] r;
    logic [TAG_W-1:0] ta, tb, tc, td;
    logic [OFF_W-1:0] o;
    void'($urandom(32'd1234));

    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R10 reset outputs", result(), EXP_IDLE);
    lookup(30'h0ABCDEF, 13'h020, 0, 1, r);
    check("R10 empty after reset", r, EXP_MISS);

    ta = 30'h0000_0010;
    fill(ta, 2'b11, 2'b11);
    lookup(ta, 13'h020, 0, 0, r);
    check("R1 hit read user", r, exp_hit(ppn_of(ta), 13'h020));
    lookup(ta, 13'h1FFF, 1, 1, r);
    check("R1 hit write super", r, exp_hit(ppn_of(ta), 13'h1FFF));
    @(negedge clk);
    check("R3 idle no outputs", result(), EXP_IDLE);
    lookup(30'h3FFF_FFFF, 13'h0, 0, 1, r);
    check("R2 unknown tag miss", r, EXP_MISS);

    tb = 30'h0222_0000;
    fill(tb, 2'b01, 2'b10);
    lookup(tb, 13'h5, 0, 1, r);
    check("R4 read super allowed", r, exp_hit(ppn_of(tb), 13'h5));
    lookup(tb, 13'h5, 0, 0, r);
    check("R4 read user fault", r, EXP_FAULT);
    lookup(tb, 13'h5, 1, 1, r);
    check("R4 write super fault", r, EXP_FAULT);
    lookup(tb, 13'h5, 1, 0, r);
    check("R4 write user allowed", r, exp_hit(ppn_of(tb), 13'h5));

    tc = 30'h0333_3333;
    lk_req = 1; lk_vaddr = {tc, 13'h44}; lk_write = 0; lk_super = 1;
    fill_en = 1; fill_tag = tc; fill_ppn = ppn_of(tc); fill_rd = 2'b11; fill_wr = 2'b11;
    @(negedge clk);
    lk_req = 0; fill_en = 0;
    check("R9 same-cycle fill lookup misses", result(), EXP_MISS);
    lookup(tc, 13'h44, 0, 1, r);
    check("R9 next lookup hits", r, exp_hit(ppn_of(tc), 13'h44));

    td = 30'h0444_0001;
    fill(td, 2'b11, 2'b11);
    fill(td, 2'b11, 2'b11);
    lookup(td, 13'h7, 0, 1, r);
    check("R5 R8 duplicate copies miss", r, EXP_MISS);

    pulse_flush();
    lookup(tc, 13'h44, 0, 1, r);
    check("R6 flush clears", r, EXP_MISS);
    fill(ta, 2'b11, 2'b11);
    fill(tb, 2'b11, 2'b11);
    pulse_inv(ta);
    lookup(ta, 13'h1, 0, 1, r);
    check("R7 invalidated tag misses", r, EXP_MISS);
    lookup(tb, 13'h1, 0, 1, r);
    check("R7 other tag still hits", r, exp_hit(ppn_of(tb), 13'h1));

    flush_all = 1; fill_en = 1; fill_tag = tc; fill_ppn = ppn_of(tc);
    fill_rd = 2'b11; fill_wr = 2'b11;
    @(negedge clk);
    flush_all = 0; fill_en = 0;
    lookup(tc, 13'h2, 0, 1, r);
    check("R6 fill during flush dropped", r, EXP_MISS);
    lookup(tb, 13'h2, 0, 1, r);
    check("R6 flush wins", r, EXP_MISS);

    for (int k = 0; k < 60; k++) begin
      logic [TAG_W-1:0] x, y;
      x = 30'h1000_0000 + TAG_W'(2 * k);
      y = x + 1'b1;
      fill(x, 2'b11, 2'b11);
      fill(y, 2'b11, 2'b11);
      lookup(x, 13'h9, 0, 1, r);
      check("R8 earlier fill survives", r, exp_hit(ppn_of(x), 13'h9));
      lookup(y, 13'h9, 0, 1, r);
      check("R8 later fill hits", r, exp_hit(ppn_of(y), 13'h9));
    end

    pulse_flush();
    for (int i = 0; i < NPOOL; i++) begin
      pool_tag[i] = 30'h2000_0000 | TAG_W'(i * 32'h1357);
      pool_st[i] = 0;
    end
    for (int n = 0; n < 3000; n++) begin
      int i, op;
      bit wr, sup;
      i = int'($urandom % NPOOL);
      op = int'($urandom % 100);
      if (op < 30) begin
        if (pool_st[i] == 0) begin
          pool_rd[i] = 2'($urandom);
          pool_wr[i] = 2'($urandom);
          fill(pool_tag[i], pool_rd[i], pool_wr[i]);
          for (int j = 0; j < NPOOL; j++) if (pool_st[j] == 2) pool_st[j] = 1;
          pool_st[i] = 2;
        end
      end else if (op < 34) begin
        pulse_inv(pool_tag[i]);
        pool_st[i] = 0;
      end else if (op < 35) begin
        pulse_flush();
        for (int j = 0; j < NPOOL; j++) pool_st[j] = 0;
      end else begin
        logic [36:0] e;
        o = 13'($urandom);
        wr = 1'($urandom);
        sup = 1'($urandom);
        lookup(pool_tag[i], o, wr, sup, r);
        if (pool_st[i] == 0) e = EXP_MISS;
        else e = perm_ok(wr ? pool_wr[i] : pool_rd[i], sup) ?
                 exp_hit(ppn_of(pool_tag[i]), o) : EXP_FAULT;
        if (pool_st[i] == 1 && r == EXP_MISS) e = EXP_MISS;
        check(pool_st[i] == 0 ? "R2 random absent" : "R1 R4 random resident", r, e);
      end
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule